// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

The resolver merges two groups of pending interrupt requests into a single priority level. The first group is a software request word. The second is a vector of external hardware lines. The resolved level is compared with the current interrupt priority level (IPL) of the core. When the level is strictly higher, the block emits a one-cycle trap request. On that same clock edge it latches two values into its status outputs: a bitmap of every pending source, and the winning level.

Each evaluation is armed by a check strobe, which is typically raised when the core returns from an exception. An armed evaluation runs once on the following clock edge, and the block then waits for the next strobe. Reset leaves one evaluation armed, so a request that is already pending is seen right after reset.

Software requests live in bits 4..18 of their word and map to levels 1..15. External lines live in bits 20..31 and each line's level equals its own bit index, so any external line outranks every software request.

Top module: `ilr_resolver`

## Requirements
- R1: A software request at bit i, where 4 <= i <= 18, resolves to level i-3. Bit 4 gives level 1 and bit 18 gives level 15.
- R2: An external line at bit i, where 20 <= i <= 31, resolves to level i.
- R3: When several sources are pending, the highest pending bit within a group sets the level. Any pending external line overrides every software request.
- R4: Bit i of the summary is 1 exactly when sw_req_i[i] is set with i in 4..18, or ext_irq_i[i] is set with i in 20..31. Input bits outside those ranges are ignored: they set no summary bit and produce no level.
- R5: A trap is raised only when the resolved level is nonzero and strictly greater than ipl_i. A level equal to ipl_i raises no trap.
- R6: check_i sampled high at clock edge n arms one evaluation at edge n+1. If that evaluation traps, trap_o is high for exactly the cycle after edge n+1, and summary_o and intid_o take their new values on that same edge n+1.
- R7: When an evaluation raises no trap, or no evaluation is armed, summary_o and intid_o keep their previous values.
- R8: While rst_ni is low, trap_o, summary_o and intid_o are all 0. Reset leaves one evaluation armed for the first clock edge after release.
- R9: Changing the request inputs without a check strobe raises no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sw_req_i | input | 32 | Software request word; only bits 4..18 are used |
| ext_irq_i | input | 32 | External interrupt lines; only bits 20..31 are used |
| ipl_i | input | 5 | Current interrupt priority level |
| check_i | input | 1 | Arms one evaluation on the next clock edge |
| trap_o | output | 1 | One-cycle trap request |
| summary_o | output | 32 | Bitmap of the pending sources latched at the last trap |
| intid_o | output | 5 | Winning level latched at the last trap |

## Verification
The assertions take for granted that check_i is low while reset is held. They also assume that after any cycle in which check_i is low, the inputs stay put long enough for the trap-pulse and stability properties to relate one cycle to the next. The bench drives every input on the falling edge. It holds each request pattern steady from the strobe through the evaluation edge, and it keeps check_i low during reset. Each strobe is a single cycle long, so no two evaluations overlap.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
  localparam int unsigned VEC_W  = 32;
  localparam int unsigned LVL_W  = 5;
  localparam int unsigned SW_LO  = 4;
  localparam int unsigned SW_HI  = 18;
  localparam int unsigned EXT_LO = 20;
  localparam int unsigned EXT_HI = 31;

  function automatic logic [VEC_W-1:0] range_mask(int unsigned lo, int unsigned hi);
    logic [VEC_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < VEC_W; i++) begin
      if (i >= lo && i <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ilr_prio_enc.sv
// Highest set bit within [LO..HI] -> level (i - LO + BASE)
module ilr_prio_enc #(
  parameter int unsigned VEC_W = 32,
  parameter int unsigned LVL_W = 5,
  parameter int unsigned LO    = 4,
  parameter int unsigned HI    = 18,
  parameter int unsigned BASE  = 1
) (
  input  logic [VEC_W-1:0] req_i,
  output logic             hit_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] pend_o
);
  localparam logic [VEC_W-1:0] MASK = ilr_pkg::range_mask(LO, HI);

  assign pend_o = req_i & MASK;

  always_comb begin
    hit_o = 1'b0;
    lvl_o = '0;
    for (int unsigned i = 0; i < VEC_W; i++) begin
      if (req_i[i] && (i >= LO) && (i <= HI)) begin
        hit_o = 1'b1;
        lvl_o = LVL_W'(i - LO + BASE);
      end
    end
  end
endmodule

// File: rtl/ilr_merge.sv
// External group always outranks software group
module ilr_merge #(
  parameter int unsigned VEC_W = 32,
  parameter int unsigned LVL_W = 5
) (
  input  logic             sw_hit_i,
  input  logic [LVL_W-1:0] sw_lvl_i,
  input  logic [VEC_W-1:0] sw_pend_i,
  input  logic             ext_hit_i,
  input  logic [LVL_W-1:0] ext_lvl_i,
  input  logic [VEC_W-1:0] ext_pend_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [VEC_W-1:0] summary_o
);
  always_comb begin
    if (ext_hit_i)     lvl_o = ext_lvl_i;
    else if (sw_hit_i) lvl_o = sw_lvl_i;
    else               lvl_o = '0;
  end

  assign summary_o = sw_pend_i | ext_pend_i;
endmodule

// File: rtl/ilr_gate.sv
module ilr_gate #(
  parameter int unsigned LVL_W = 5
) (
  input  logic             armed_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] ipl_i,
  output logic             fire_o
);
  assign fire_o = armed_i && (lvl_i != '0) && (lvl_i > ipl_i);
endmodule

// File: rtl/ilr_resolver.sv
module ilr_resolver #(
  parameter int unsigned VEC_W  = ilr_pkg::VEC_W,
  parameter int unsigned LVL_W  = ilr_pkg::LVL_W,
  parameter int unsigned SW_LO  = ilr_pkg::SW_LO,
  parameter int unsigned SW_HI  = ilr_pkg::SW_HI,
  parameter int unsigned EXT_LO = ilr_pkg::EXT_LO,
  parameter int unsigned EXT_HI = ilr_pkg::EXT_HI
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VEC_W-1:0] sw_req_i,
  input  logic [VEC_W-1:0] ext_irq_i,
  input  logic [LVL_W-1:0] ipl_i,
  input  logic             check_i,
  output logic             trap_o,
  output logic [VEC_W-1:0] summary_o,
  output logic [LVL_W-1:0] intid_o
);
  logic             sw_hit, ext_hit, armed_q, fire;
  logic [LVL_W-1:0] sw_lvl, ext_lvl, lvl;
  logic [VEC_W-1:0] sw_pend, ext_pend, summary;

  ilr_prio_enc #(.VEC_W(VEC_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI), .BASE(1)) u_sw_enc (
    .req_i(sw_req_i), .hit_o(sw_hit), .lvl_o(sw_lvl), .pend_o(sw_pend)
  );

  ilr_prio_enc #(.VEC_W(VEC_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI), .BASE(EXT_LO)) u_ext_enc (
    .req_i(ext_irq_i), .hit_o(ext_hit), .lvl_o(ext_lvl), .pend_o(ext_pend)
  );

  ilr_merge #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_merge (
    .sw_hit_i(sw_hit), .sw_lvl_i(sw_lvl), .sw_pend_i(sw_pend),
    .ext_hit_i(ext_hit), .ext_lvl_i(ext_lvl), .ext_pend_i(ext_pend),
    .lvl_o(lvl), .summary_o(summary)
  );

  ilr_gate #(.LVL_W(LVL_W)) u_gate (
    .armed_i(armed_q), .lvl_i(lvl), .ipl_i(ipl_i), .fire_o(fire)
  );

  // one evaluation armed out of reset, then one per strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= check_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_o    <= 1'b0;
      summary_o <= '0;
      intid_o   <= '0;
    end else begin
      trap_o <= fire;
      if (fire) begin
        summary_o <= summary;
        intid_o   <= lvl;
      end
    end
  end
endmodule

// File: rtl/ilr_resolver_chk.sv
module ilr_resolver_chk #(
  parameter int unsigned VEC_W  = 32,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned SW_LO  = 4,
  parameter int unsigned SW_HI  = 18,
  parameter int unsigned EXT_LO = 20,
  parameter int unsigned EXT_HI = 31
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VEC_W-1:0] sw_req_i,
  input logic [VEC_W-1:0] ext_irq_i,
  input logic [LVL_W-1:0] ipl_i,
  input logic             check_i,
  input logic             trap_o,
  input logic [VEC_W-1:0] summary_o,
  input logic [LVL_W-1:0] intid_o
);
  localparam logic [VEC_W-1:0] SW_M  = ilr_pkg::range_mask(SW_LO, SW_HI);
  localparam logic [VEC_W-1:0] EXT_M = ilr_pkg::range_mask(EXT_LO, EXT_HI);

  assert_trap_above_ipl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (intid_o != '0) && (intid_o > $past(ipl_i)));

  assert_trap_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !$past(check_i)) |=> !trap_o);

  assert_status_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trap_o |-> ($stable(summary_o) && $stable(intid_o)));

  assert_ext_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && ((summary_o & EXT_M) != '0)) |-> (intid_o >= LVL_W'(EXT_LO)));

  assert_summary_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (summary_o & ~(SW_M | EXT_M)) == '0);

  assert_summary_matches_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (summary_o == (($past(sw_req_i) & SW_M) | ($past(ext_irq_i) & EXT_M))));
endmodule

bind ilr_resolver ilr_resolver_chk #(
  .VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI), .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sw_req_i(sw_req_i), .ext_irq_i(ext_irq_i),
  .ipl_i(ipl_i), .check_i(check_i), .trap_o(trap_o), .summary_o(summary_o), .intid_o(intid_o)
);

// File: tb/ilr_resolver_test.sv
`timescale 1ns/1ps
module ilr_resolver_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] sw_req_i = '0;
  logic [31:0] ext_irq_i = '0;
  logic [4:0]  ipl_i = '0;
  logic        check_i = 1'b0;
  logic        trap_o;
  logic [31:0] summary_o;
  logic [4:0]  intid_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_sum = '0;
  logic [4:0]  m_id = '0;

  always #5 clk_i = ~clk_i;

  ilr_resolver uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_req_i(sw_req_i), .ext_irq_i(ext_irq_i),
    .ipl_i(ipl_i), .check_i(check_i), .trap_o(trap_o), .summary_o(summary_o), .intid_o(intid_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_lvl(input logic [31:0] sw, input logic [31:0] ext);
    logic [4:0] l;
    l = '0;
    for (int i = 4; i <= 18; i++) if (sw[i]) l = 5'(i - 3);
    for (int i = 20; i <= 31; i++) if (ext[i]) l = 5'(i);
    return l;
  endfunction

  function automatic logic [31:0] exp_sum(input logic [31:0] sw, input logic [31:0] ext);
    return (sw & 32'h0007_fff0) | (ext & 32'hfff0_0000);
  endfunction

  // strobe, evaluate, sample trap cycle and the cycle after
  task automatic eval_case(input string tag, input logic [31:0] sw, input logic [31:0] ext,
                           input logic [4:0] ipl);
    logic [4:0] l;
    bit fire;
    l = exp_lvl(sw, ext);
    fire = (l != 0) && (l > ipl);
    if (fire) begin
      m_sum = exp_sum(sw, ext);
      m_id  = l;
    end
    sw_req_i = sw; ext_irq_i = ext; ipl_i = ipl; check_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    check_i = 1'b0;
    chk(trap_o == 1'b0, {tag, " R6 no early trap"}, 32'(trap_o), 0);
    @(posedge clk_i); @(negedge clk_i);
    chk(trap_o == fire, {tag, " trap"}, 32'(trap_o), 32'(fire));
    chk(summary_o == m_sum, {tag, " summary"}, summary_o, m_sum);
    chk(intid_o == m_id, {tag, " intid"}, 32'(intid_o), 32'(m_id));
    @(posedge clk_i); @(negedge clk_i);
    chk(trap_o == 1'b0, {tag, " R6 pulse width"}, 32'(trap_o), 0);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(trap_o == 0 && summary_o == 0 && intid_o == 0, "R8 reset state", summary_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk(trap_o == 0, "R8 idle after reset", 32'(trap_o), 0);
  endtask

  task automatic t_no_strobe();
    sw_req_i = 32'h0004_0000; ext_irq_i = 32'h8000_0000; ipl_i = '0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_i); @(negedge clk_i);
      chk(trap_o == 0, "R9 no trap without strobe", 32'(trap_o), 0);
    end
    chk(summary_o == m_sum && intid_o == m_id, "R7 status held without strobe", summary_o, m_sum);
  endtask

  task automatic t_reset_armed();
    rst_ni = 1'b0; ext_irq_i = 32'h0200_0000; sw_req_i = '0; ipl_i = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    chk(trap_o == 1, "R8 armed evaluation after reset", 32'(trap_o), 1);
    chk(intid_o == 5'd25, "R8 intid after reset", 32'(intid_o), 25);
    chk(summary_o == 32'h0200_0000, "R8 summary after reset", summary_o, 32'h0200_0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    eval_case("R1 sw bit4", 32'h0000_0010, '0, 5'd0);
    eval_case("R1 sw bit18", 32'h0004_0000, '0, 5'd0);
    eval_case("R2 ext bit20", '0, 32'h0010_0000, 5'd0);
    eval_case("R2 ext bit31", '0, 32'h8000_0000, 5'd0);
    eval_case("R3 highest sw", 32'h0000_1110, '0, 5'd0);
    eval_case("R3 ext over sw", 32'h0004_0010, 32'h0040_0000, 5'd0);
    eval_case("R3 highest ext", 32'h0000_0100, 32'h0900_0000, 5'd0);
    eval_case("R5 equal ipl", 32'h0000_0200, '0, 5'd6);
    eval_case("R5 one above ipl", 32'h0000_0200, '0, 5'd5);
    eval_case("R7 nothing pending", '0, '0, 5'd0);
    eval_case("R4 out of range only", 32'hfff8_000f, 32'h000f_ffff, 5'd0);
    eval_case("R4 mixed in and out", 32'h0008_0028, 32'h0008_0000, 5'd0);
    eval_case("R5 ext below ipl", '0, 32'h0010_0000, 5'd31);
    t_no_strobe();
    t_reset_armed();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule